// File: doc/BRIEF.md
# Sleep and Watchdog Status Controller

This block is the power-management corner of a small microcontroller core. The decode stage gives it a strobe when the sleep command is being executed. The block acts on that strobe only in the last of the four phases of the instruction cycle. When it acts, it drops the oscillator enable, marks the core as sleeping and sets the two status flags to their fixed sleep polarities. These flags are `to_o`, the time-out flag, and `pd_o`, the power-down flag. At the same moment it clears the watchdog counter and its postscaler.

The watchdog is driven by a separate tick input, so it keeps counting while the core clock is stopped. Each tick advances a postscaler. Each wrap of the postscaler advances the main counter. A wrap of the main counter produces a one-cycle time-out pulse. The two wake-up paths leave different traces in the status flags. A watchdog time-out clears the time-out flag. An external wake request leaves both flags as they were, so software can tell afterwards what woke the core.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low: `to_o`=1, `pd_o`=1, `sleeping_o`=0, `osc_en_o`=1 and `wdt_timeout_o`=0. The postscaler and the watchdog counter are held at zero.
- R2: Sleep entry happens when `sleep_cmd_i`=1 is sampled with `q_phase_i`=2'd3 (the enter-sleep phase) while awake. After that edge, `sleeping_o`=1 and `osc_en_o`=0.
- R3: Sleep entry sets `to_o` to 1 and clears `pd_o` to 0 on the same edge as R2.
- R4: Sleep entry clears the postscaler and the watchdog counter. The next time-out then needs a full PS_RATIO*2^CNT_W further ticks.
- R5: A sleep strobe has no effect in phases 2'd0 to 2'd2, and no effect while already sleeping.
- R6: The edge that samples tick number PS_RATIO*2^CNT_W since the last clear raises `wdt_timeout_o` for exactly one cycle. The count then restarts from zero, and it also advances while sleeping.
- R7: A time-out while sleeping wakes the core on that same edge (`sleeping_o`=0, `osc_en_o`=1) and clears `to_o` to 0. `pd_o` stays 0.
- R8: A `wake_req_i` sampled while sleeping wakes the core on that edge and leaves `to_o` and `pd_o` unchanged. Sampled while awake, it has no effect.
- R9: A time-out while awake clears `to_o` and leaves `sleeping_o` and `pd_o` unchanged.
- R10: `osc_en_o` is always the inverse of `sleeping_o`.
- R11: On one edge, sleep entry takes priority over a watchdog tick: the tick is dropped and no time-out occurs. A time-out takes priority over a simultaneous wake request, so `to_o` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sleep_cmd_i | input | 1 | Decoded sleep-command strobe |
| wdt_tick_i | input | 1 | Watchdog time-base tick |
| wake_req_i | input | 1 | External wake request |
| q_phase_i | input | 2 | Phase index within the instruction cycle, 3 = enter-sleep |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |
| osc_en_o | output | 1 | Oscillator enable, low while asleep |
| sleeping_o | output | 1 | Core is in sleep |
| wdt_timeout_o | output | 1 | One-cycle watchdog time-out pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the oscillator enable always mirrors the sleep flag;
- an enter-phase strobe always lands in sleep with the fixed flag polarities;
- a strobe outside the enter phase never puts the core to sleep;
- the time-out pulse never lasts two cycles, and it always leaves the time-out flag cleared;
- a wake with no time-out never disturbs the flags.

Other behaviour only the bench's scenarios can show, because it depends on counting many ticks: the exact tick on which the time-out fires, the restart of the count after a sleep entry, and the same-edge priority cases.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  typedef enum logic [1:0] {
    PH_DECODE  = 2'd0,
    PH_IDLE    = 2'd1,
    PH_PROCESS = 2'd2,
    PH_ENTER   = 2'd3
  } q_phase_e;

  typedef struct packed {
    logic to;
    logic pd;
  } pwr_status_t;

  localparam pwr_status_t STATUS_POR   = '{to: 1'b1, pd: 1'b1};
  localparam pwr_status_t STATUS_SLEEP = '{to: 1'b1, pd: 1'b0};
endpackage

// File: rtl/sleep_entry_dec.sv
module sleep_entry_dec
  import pwr_sleep_pkg::*;
(
  input  logic       sleep_cmd_i,
  input  logic [1:0] q_phase_i,
  input  logic       sleeping_i,
  output logic       enter_o
);
  q_phase_e phase;
  assign phase   = q_phase_e'(q_phase_i);
  // act only in the last phase, and only once per sleep
  assign enter_o = sleep_cmd_i && (phase == PH_ENTER) && !sleeping_i;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned PS_RATIO = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic ovf_o,
  output logic timeout_o
);
  localparam int unsigned PS_W = (PS_RATIO > 1) ? $clog2(PS_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic ps_wrap;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PS_RATIO > 1) begin : g_ps
      localparam logic [PS_W-1:0] PS_MAX = PS_W'(PS_RATIO - 1);
      logic [PS_W-1:0] ps_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ps_q <= '0;
        else if (clear_i)            ps_q <= '0;
        else if (tick_i) ps_q <= (ps_q == PS_MAX) ? '0 : ps_q + 1'b1;
      end
      assign ps_wrap = tick_i && (ps_q == PS_MAX);
    end else begin : g_no_ps
      assign ps_wrap = tick_i;
    end
  endgenerate

  // clear wins over a same-edge tick
  assign ovf_o = !clear_i && ps_wrap && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (ps_wrap)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_o <= 1'b0;
    else         timeout_o <= ovf_o;
  end
endmodule

// File: rtl/status_flags.sv
module status_flags
  import pwr_sleep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic ovf_i,
  output logic to_o,
  output logic pd_o
);
  pwr_status_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (enter_i)    st_d = STATUS_SLEEP;
    else if (ovf_i) st_d.to = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= STATUS_POR;
    else         st_q <= st_d;
  end

  assign to_o = st_q.to;
  assign pd_o = st_q.pd;
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic wake_i,
  input  logic ovf_i,
  output logic sleeping_o,
  output logic osc_en_o
);
  logic sleep_d;

  always_comb begin
    sleep_d = sleeping_o;
    if (enter_i)                        sleep_d = 1'b1;
    else if (sleeping_o && (ovf_i || wake_i)) sleep_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleeping_o <= 1'b0;
      osc_en_o   <= 1'b1;
    end else begin
      sleeping_o <= sleep_d;
      osc_en_o   <= !sleep_d;
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl #(
  parameter int unsigned PS_RATIO = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_cmd_i,
  input  logic       wdt_tick_i,
  input  logic       wake_req_i,
  input  logic [1:0] q_phase_i,
  output logic       to_o,
  output logic       pd_o,
  output logic       osc_en_o,
  output logic       sleeping_o,
  output logic       wdt_timeout_o
);
  logic enter, ovf;

  sleep_entry_dec i_dec (
    .sleep_cmd_i(sleep_cmd_i),
    .q_phase_i  (q_phase_i),
    .sleeping_i (sleeping_o),
    .enter_o    (enter)
  );

  wdt_core #(.PS_RATIO(PS_RATIO), .CNT_W(CNT_W)) i_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (enter),
    .tick_i   (wdt_tick_i),
    .ovf_o    (ovf),
    .timeout_o(wdt_timeout_o)
  );

  status_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .enter_i(enter),
    .ovf_i  (ovf),
    .to_o   (to_o),
    .pd_o   (pd_o)
  );

  sleep_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (enter),
    .wake_i    (wake_req_i),
    .ovf_i     (ovf),
    .sleeping_o(sleeping_o),
    .osc_en_o  (osc_en_o)
  );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_cmd_i,
  input logic       wake_req_i,
  input logic [1:0] q_phase_i,
  input logic       to_o,
  input logic       pd_o,
  input logic       osc_en_o,
  input logic       sleeping_o,
  input logic       wdt_timeout_o
);
  always_comb begin
    if (rst_ni) assert_osc_mirror_R10: assert (osc_en_o == !sleeping_o);
  end

  assert_enter_sleep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_cmd_i && q_phase_i == 2'd3 && !sleeping_o) |=> (sleeping_o && !osc_en_o));

  assert_enter_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_cmd_i && q_phase_i == 2'd3 && !sleeping_o) |=> (to_o && !pd_o));

  assert_wrong_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_cmd_i && q_phase_i != 2'd3 && !sleeping_o) |=> !sleeping_o);

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_o |=> !wdt_timeout_o);

  assert_timeout_clears_to_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_o |-> !to_o);

  assert_ext_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && wake_req_i) |=> !sleeping_o);

  assert_ext_wake_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sleeping_o) && !wdt_timeout_o) |-> ($stable(to_o) && !pd_o));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_cmd_i  (sleep_cmd_i),
  .wake_req_i   (wake_req_i),
  .q_phase_i    (q_phase_i),
  .to_o         (to_o),
  .pd_o         (pd_o),
  .osc_en_o     (osc_en_o),
  .sleeping_o   (sleeping_o),
  .wdt_timeout_o(wdt_timeout_o)
);

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PS_RATIO   = 4;
  localparam int CNT_W      = 4;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int PERIOD     = PS_RATIO * (1 << CNT_W);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_cmd = 1'b0, tick = 1'b0, wake = 1'b0;
  logic [1:0] phase = 2'd0;
  logic to, pd, osc_en, sleeping, timeout;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int m_ps = 0, m_cnt = 0, m_to = 1, m_pd = 1, m_sl = 0, m_tmo = 0;
  int ph = 0;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.PS_RATIO(PS_RATIO), .CNT_W(CNT_W)) i_pwr_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_cmd_i(sleep_cmd), .wdt_tick_i(tick),
    .wake_req_i(wake), .q_phase_i(phase), .to_o(to), .pd_o(pd),
    .osc_en_o(osc_en), .sleeping_o(sleeping), .wdt_timeout_o(timeout)
  );

  task automatic chk1(string what, logic act, int exp);
    n_checks++;
    if (act !== exp[0]) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %b expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk1("to_o", to, m_to);
    chk1("pd_o", pd, m_pd);
    chk1("sleeping_o", sleeping, m_sl);
    chk1("osc_en_o", osc_en, (m_sl == 0) ? 1 : 0);
    chk1("wdt_timeout_o", timeout, m_tmo);
  endtask

  // drive at negedge, predict the next posedge, compare at following negedge
  task automatic step(bit s, bit t, bit w, int p);
    bit entry, ovf;
    sleep_cmd = s; tick = t; wake = w; phase = 2'(p);
    entry = s && (p == 3) && (m_sl == 0);
    ovf = 0;
    if (entry) begin
      m_ps = 0; m_cnt = 0; m_sl = 1; m_to = 1; m_pd = 0;
    end else begin
      if (t) begin
        if (m_ps == PS_RATIO - 1) begin
          m_ps = 0;
          if (m_cnt == CNT_MAX) begin m_cnt = 0; ovf = 1; end
          else m_cnt++;
        end else m_ps++;
      end
      if (ovf) begin m_to = 0; m_sl = 0; end
      else if (w && m_sl == 1) m_sl = 0;
    end
    m_tmo = ovf;
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run(bit s, bit t, bit w);
    step(s, t, w, ph);
    ph = (ph + 1) % 4;
  endtask

  task automatic sleep_now();
    while (ph != 3) run(0, 0, 0);
    run(1, 0, 0);
  endtask

  task automatic ticks_to_edge();
    // stop one tick before overflow
    while (!(m_ps == PS_RATIO - 1 && m_cnt == CNT_MAX)) run(0, 1, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    tag = "R1"; m_tmo = 0;
    compare();
    rst_ni = 1'b1;
    run(0, 0, 0); run(0, 0, 0);

    tag = "R9";
    for (int i = 0; i < PERIOD + 3; i++) run(0, 1, 0);

    tag = "R5";
    run(0, 0, 0); run(1, 0, 0); run(1, 0, 0); run(1, 0, 0);

    tag = "R3";
    sleep_now();
    tag = "R5";
    for (int i = 0; i < 6; i++) run(1, 0, 0);

    tag = "R8";
    for (int i = 0; i < 10; i++) run(0, 1, 0);
    run(0, 0, 1);
    run(0, 0, 1);

    tag = "R2";
    sleep_now();
    tag = "R6";
    for (int i = 0; i < PERIOD - 1; i++) run(0, 1, 0);
    tag = "R7";
    run(0, 1, 0);
    run(0, 0, 0);

    tag = "R4";
    for (int i = 0; i < 30; i++) run(0, 1, 0);
    while (ph != 3) run(0, 0, 0);
    run(1, 1, 0);
    for (int i = 0; i < PERIOD; i++) run(0, 1, 0);
    run(0, 0, 1);

    tag = "R11";
    ticks_to_edge();
    step(1, 1, 0, 3); ph = 0;
    ticks_to_edge();
    run(0, 1, 1);
    run(0, 0, 0);

    tag = "R10";
    for (int i = 0; i < 3000; i++)
      run(($urandom % 8) == 0, ($urandom % 3) != 0, ($urandom % 40) == 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule